// File: doc/BRIEF.md
# Asynchronous SRAM Bus Timing Monitor

This block watches the control, address and data lines of an asynchronous static memory bus and samples them on a fast free-running clock. It performs no bus transfers and stores no data. On every sample it decodes the bus mode from the three active-low strobes. It times the strobe pulses, the data and address stable windows and the write-strobe gaps in whole sample ticks, and sets a sticky flag when one of seven timing rules is broken.

Every nanosecond limit becomes a tick limit equal to the ceiling of the limit divided by the sample period. The sample period is given in picoseconds by `SAMPLE_PS`, with a default of 2500 ps. At the default, the limits in ticks are: write pulse 24, chip-enable write window 32, data setup 16, address cycle 40, driver turn-around 12, and write gap 2. An event counter adds the number of rules broken in each sample and saturates at all ones. A synchronous clear input empties both the flags and the counter.

Top module: `asram_timing_mon`

## Requirements
- R1: `bus_mode` follows the strobes in the same cycle with this encoding: 0 when `ce_n` is high (standby), 1 when `ce_n` and `we_n` are both low (write, `oe_n` ignored), 2 when `ce_n` is low, `we_n` is high and `oe_n` is low (read), and 3 when `ce_n` is low and both `we_n` and `oe_n` are high (enabled, outputs off).
- R2: A write that ends because `we_n` rises while `ce_n` stays low, after fewer than 24 write samples, sets flag bit 0. Exactly 24 samples does not set it.
- R3: A write that ends because `ce_n` rises, after fewer than 32 consecutive samples with `ce_n` low, sets flag bit 1. This rule wins when both strobes rise together.
- R4: At the end of any write, if `bus_data` or `host_drv` changed fewer than 16 samples earlier, flag bit 2 is set. Exactly 16 samples does not set it.
- R5: An address change seen while `ce_n` is low in both the current and the previous sample, fewer than 40 samples after the previous address change, sets flag bit 3. Exactly 40 samples does not set it.
- R6: When `host_drv` is high during a write with `oe_n` low, fewer than 12 samples after the write began, flag bit 4 is set. This counts as one event for each unbroken stretch of the condition. Driving from the 12th sample onward does not set it.
- R7: A fall of `we_n` with `ce_n` low, after a write that `we_n` ended in the same chip-enable period and after fewer than 2 high samples, sets flag bit 5.
- R8: An address change between two consecutive write samples sets flag bit 6.
- R9: Flags and count change on the clock edge that captures the offending sample. The count rises by the number of rules broken in that sample. Flags stay set until cleared.
- R10: `clr` high at an edge leaves all flags and the count at zero after that edge, even when a rule is broken in the same sample.
- R11: After reset, all flags and the count are zero. The stable-time counters start full, so the first address change after reset with `ce_n` low is not a cycle violation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clr | input | 1 | Synchronous clear of flags and count |
| bus_addr | input | 19 | Observed memory address |
| bus_data | input | 8 | Observed data lines |
| host_drv | input | 1 | High while the host drives the data lines |
| ce_n | input | 1 | Observed active-low chip enable |
| we_n | input | 1 | Observed active-low write enable |
| oe_n | input | 1 | Observed active-low output enable |
| bus_mode | output | 2 | Decoded bus mode for the current sample |
| err_flags | output | 7 | Sticky per-rule violation flags |
| err_count | output | 16 | Saturating count of violation events |

## Verification
`bus_mode` is combinational and is checked one time step after the strobes change, before any clock edge. Flags and count move on the first rising edge that captures the offending sample, so the bench drives each sample just after a falling edge and reads results at the next falling edge. Every interval scenario is run once just inside a limit and once at the limit, so a one-tick error in a counter or a comparison shows up as a wrong flag at that falling edge.

// File: rtl/asram_mon_pkg.sv
package asram_mon_pkg;

  typedef enum logic [1:0] {
    MODE_STANDBY = 2'd0,
    MODE_WRITE   = 2'd1,
    MODE_READ    = 2'd2,
    MODE_QUIET   = 2'd3
  } bus_mode_e;

  localparam int NRULE       = 7;
  localparam int RULE_WPULSE = 0;
  localparam int RULE_CEWIN  = 1;
  localparam int RULE_SETUP  = 2;
  localparam int RULE_CYCLE  = 3;
  localparam int RULE_CONTD  = 4;
  localparam int RULE_WGAP   = 5;
  localparam int RULE_AINWR  = 6;

  localparam int NSPAN       = 5;
  localparam int SPAN_WE_LO  = 0;
  localparam int SPAN_CE_LO  = 1;
  localparam int SPAN_WE_HI  = 2;
  localparam int SPAN_DATA   = 3;
  localparam int SPAN_ADDR   = 4;

  // Ticks needed to cover a nanosecond limit at a picosecond sample period.
  function automatic int ticks_ceil(input int lim_ns, input int period_ps);
    return (lim_ns * 1000 + period_ps - 1) / period_ps;
  endfunction

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int bits_for(input int v);
    return $clog2(v + 1);
  endfunction

endpackage

// File: rtl/asram_mode_decode.sv
module asram_mode_decode
  import asram_mon_pkg::*;
(
  input  logic      ce_n,
  input  logic      we_n,
  input  logic      oe_n,
  output bus_mode_e mode,
  output logic      write_act
);
  always_comb begin
    if (ce_n)      mode = MODE_STANDBY;
    else if (!we_n) mode = MODE_WRITE;
    else if (!oe_n) mode = MODE_READ;
    else           mode = MODE_QUIET;
  end

  assign write_act = (mode == MODE_WRITE);
endmodule

// File: rtl/asram_span_ctr.sv
module asram_span_ctr #(
  parameter int CW       = 7,
  parameter bit SAT_INIT = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          advance,
  input  logic          zero,
  output logic [CW-1:0] q
);
  localparam logic [CW-1:0] TOP = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     q <= SAT_INIT ? TOP : '0;
    else if (zero)                  q <= '0;
    else if (restart)               q <= CW'(1);
    else if (advance && q != TOP)   q <= q + 1'b1;
  end

  // R5: a full counter never wraps back to a small value by itself
  p_span_saturates_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (q == TOP && !zero && !restart) |=> (q == TOP));
endmodule

// File: rtl/asram_rule_eval.sv
module asram_rule_eval
  import asram_mon_pkg::*;
#(
  parameter int CW     = 7,
  parameter int WP_T   = 24,
  parameter int CEP_T  = 32,
  parameter int SU_T   = 16,
  parameter int CYC_T  = 40,
  parameter int TURN_T = 12,
  parameter int GAP_T  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce_n,
  input  logic             we_n,
  input  logic             oe_n,
  input  logic             host_drv,
  input  logic             write_act,
  input  logic             write_q,
  input  logic             we_q,
  input  logic             ce_q,
  input  logic             addr_chg,
  input  logic [CW-1:0]    span_we_lo,
  input  logic [CW-1:0]    span_ce_lo,
  input  logic [CW-1:0]    span_we_hi,
  input  logic [CW-1:0]    span_data,
  input  logic [CW-1:0]    span_addr,
  output logic [NRULE-1:0] viol
);
  localparam logic [CW-1:0] LIM_WP   = CW'(WP_T);
  localparam logic [CW-1:0] LIM_CEP  = CW'(CEP_T);
  localparam logic [CW-1:0] LIM_SU   = CW'(SU_T);
  localparam logic [CW-1:0] LIM_CYC  = CW'(CYC_T);
  localparam logic [CW-1:0] LIM_TURN = CW'(TURN_T);
  localparam logic [CW-1:0] LIM_GAP  = CW'(GAP_T);

  logic end_write, end_by_we, end_by_ce, we_fall, cont_now;
  logic cont_q, had_write;

  // named events for the assertions
  assign end_write = write_q && !write_act;
  assign end_by_we = end_write && !ce_n;
  assign end_by_ce = end_write && ce_n;
  assign we_fall   = we_q && !we_n && !ce_n;
  assign cont_now  = write_act && !oe_n && host_drv && (span_we_lo < LIM_TURN);

  always_comb begin
    viol              = '0;
    viol[RULE_WPULSE] = end_by_we && (span_we_lo < LIM_WP);
    viol[RULE_CEWIN]  = end_by_ce && (span_ce_lo < LIM_CEP);
    viol[RULE_SETUP]  = end_write && (span_data < LIM_SU);
    viol[RULE_CYCLE]  = addr_chg && !ce_n && !ce_q && (span_addr < LIM_CYC);
    viol[RULE_CONTD]  = cont_now && !cont_q;
    viol[RULE_WGAP]   = we_fall && had_write && (span_we_hi < LIM_GAP);
    viol[RULE_AINWR]  = addr_chg && write_act && write_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cont_q    <= 1'b0;
      had_write <= 1'b0;
    end else begin
      cont_q <= cont_now;
      if (ce_n)           had_write <= 1'b0;
      else if (end_by_we) had_write <= 1'b1;
    end
  end

  p_wpulse_at_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    viol[RULE_WPULSE] |-> (!ce_n && we_n));
  p_cewin_at_deselect_r3: assert property (@(posedge clk) disable iff (!rst_n)
    viol[RULE_CEWIN] |-> ce_n);
  p_setup_after_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    viol[RULE_SETUP] |-> (ce_n || we_n));
  p_cycle_enabled_r5: assert property (@(posedge clk) disable iff (!rst_n)
    viol[RULE_CYCLE] |-> !ce_n);
  p_contention_drive_r6: assert property (@(posedge clk) disable iff (!rst_n)
    viol[RULE_CONTD] |-> (host_drv && !oe_n && !we_n && !ce_n));
  p_contention_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
    viol[RULE_CONTD] |=> !viol[RULE_CONTD]);
  p_gap_on_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    viol[RULE_WGAP] |-> (!we_n && !ce_n && $past(we_n)));
  p_addr_in_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    viol[RULE_AINWR] |-> (!we_n && !ce_n && !$past(we_n)));
endmodule

// File: rtl/asram_err_accum.sv
module asram_err_accum #(
  parameter int NR    = 7,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [NR-1:0]    viol,
  output logic [NR-1:0]    flags,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] HEADROOM = {CNT_W{1'b1}} - CNT_W'(NR);

  logic [CNT_W:0] sum;

  assign sum = {1'b0, count} + (CNT_W+1)'($countones(viol));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= '0;
      count <= '0;
    end else if (clr) begin
      flags <= '0;
      count <= '0;
    end else begin
      flags <= flags | viol;
      count <= sum[CNT_W] ? {CNT_W{1'b1}} : sum[CNT_W-1:0];
    end
  end

  p_flags_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((flags & $past(flags)) == $past(flags)));
  p_count_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && count < HEADROOM) |=>
      (count == $past(count) + CNT_W'($countones($past(viol)))));
  p_flags_need_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (flags != '0) |-> (count != '0));
  p_clear_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (flags == '0 && count == '0));
endmodule

// File: rtl/asram_timing_mon.sv
module asram_timing_mon
  import asram_mon_pkg::*;
#(
  parameter int ADDR_W     = 19,
  parameter int DATA_W     = 8,
  parameter int CNT_W      = 16,
  parameter int SAMPLE_PS  = 2500,
  parameter int WPULSE_NS  = 60,
  parameter int CEWIN_NS   = 80,
  parameter int SETUP_NS   = 40,
  parameter int CYCLE_NS   = 100,
  parameter int TURN_NS    = 30,
  parameter int WGAP_NS    = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_data,
  input  logic              host_drv,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  output logic [1:0]        bus_mode,
  output logic [NRULE-1:0]  err_flags,
  output logic [CNT_W-1:0]  err_count
);
  localparam int WP_T   = ticks_ceil(WPULSE_NS, SAMPLE_PS);
  localparam int CEP_T  = ticks_ceil(CEWIN_NS, SAMPLE_PS);
  localparam int SU_T   = ticks_ceil(SETUP_NS, SAMPLE_PS);
  localparam int CYC_T  = ticks_ceil(CYCLE_NS, SAMPLE_PS);
  localparam int TURN_T = ticks_ceil(TURN_NS, SAMPLE_PS);
  localparam int GAP_T  = ticks_ceil(WGAP_NS, SAMPLE_PS);
  localparam int MAX_T  = max_of(max_of(max_of(WP_T, CEP_T), max_of(SU_T, CYC_T)),
                                 max_of(TURN_T, GAP_T));
  localparam int CW     = bits_for(MAX_T) + 1;

  bus_mode_e mode;
  logic      write_act;

  // one-sample history of the bus
  logic              prev_vld;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic              drv_q, ce_q, we_q, write_q;
  logic              addr_chg, data_chg;

  logic [NSPAN-1:0]  span_restart, span_advance, span_zero;
  logic [CW-1:0]     span_q [NSPAN];
  logic [NRULE-1:0]  viol;

  asram_mode_decode u_decode (
    .ce_n      (ce_n),
    .we_n      (we_n),
    .oe_n      (oe_n),
    .mode      (mode),
    .write_act (write_act)
  );

  assign bus_mode = mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_vld <= 1'b0;
      addr_q   <= '0;
      data_q   <= '0;
      drv_q    <= 1'b0;
      ce_q     <= 1'b1;
      we_q     <= 1'b1;
      write_q  <= 1'b0;
    end else begin
      prev_vld <= 1'b1;
      addr_q   <= bus_addr;
      data_q   <= bus_data;
      drv_q    <= host_drv;
      ce_q     <= ce_n;
      we_q     <= we_n;
      write_q  <= write_act;
    end
  end

  assign addr_chg = prev_vld && (bus_addr != addr_q);
  assign data_chg = prev_vld && ({host_drv, bus_data} != {drv_q, data_q});

  always_comb begin
    span_restart = '0;
    span_advance = '0;
    span_zero    = '0;
    span_advance[SPAN_WE_LO] = write_act;
    span_zero[SPAN_WE_LO]    = !write_act;
    span_advance[SPAN_CE_LO] = !ce_n;
    span_zero[SPAN_CE_LO]    = ce_n;
    span_advance[SPAN_WE_HI] = we_n;
    span_zero[SPAN_WE_HI]    = !we_n;
    span_restart[SPAN_DATA]  = data_chg;
    span_advance[SPAN_DATA]  = 1'b1;
    span_restart[SPAN_ADDR]  = addr_chg;
    span_advance[SPAN_ADDR]  = 1'b1;
  end

  generate
    for (genvar g = 0; g < NSPAN; g++) begin : g_span
      asram_span_ctr #(
        .CW       (CW),
        .SAT_INIT (g >= SPAN_DATA)
      ) u_span (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (span_restart[g]),
        .advance (span_advance[g]),
        .zero    (span_zero[g]),
        .q       (span_q[g])
      );
    end
  endgenerate

  asram_rule_eval #(
    .CW     (CW),
    .WP_T   (WP_T),
    .CEP_T  (CEP_T),
    .SU_T   (SU_T),
    .CYC_T  (CYC_T),
    .TURN_T (TURN_T),
    .GAP_T  (GAP_T)
  ) u_rules (
    .clk        (clk),
    .rst_n      (rst_n),
    .ce_n       (ce_n),
    .we_n       (we_n),
    .oe_n       (oe_n),
    .host_drv   (host_drv),
    .write_act  (write_act),
    .write_q    (write_q),
    .we_q       (we_q),
    .ce_q       (ce_q),
    .addr_chg   (addr_chg),
    .span_we_lo (span_q[SPAN_WE_LO]),
    .span_ce_lo (span_q[SPAN_CE_LO]),
    .span_we_hi (span_q[SPAN_WE_HI]),
    .span_data  (span_q[SPAN_DATA]),
    .span_addr  (span_q[SPAN_ADDR]),
    .viol       (viol)
  );

  asram_err_accum #(
    .NR    (NRULE),
    .CNT_W (CNT_W)
  ) u_accum (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (clr),
    .viol  (viol),
    .flags (err_flags),
    .count (err_count)
  );

  p_standby_decode_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |-> (bus_mode == 2'd0));
  p_write_decode_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && !we_n) |-> (bus_mode == 2'd1));
  p_no_change_first_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !prev_vld |-> !viol[RULE_CYCLE]);
endmodule

// File: tb/asram_timing_mon_test.sv
module asram_timing_mon_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clr = 1'b0;
  logic [18:0] bus_addr = 19'd3;
  logic [7:0]  bus_data = 8'h00;
  logic        host_drv = 1'b0;
  logic        ce_n = 1'b0;
  logic        we_n = 1'b1;
  logic        oe_n = 1'b1;
  logic [1:0]  bus_mode;
  logic [6:0]  err_flags;
  logic [15:0] err_count;

  int checks = 0;
  int fails  = 0;

  localparam logic [18:0] AA = 19'h1_2345;
  localparam logic [18:0] AB = 19'h0_0F0F;
  localparam logic [7:0]  DA = 8'hA5;
  localparam logic [7:0]  DB = 8'h3C;

  always #5 clk = ~clk;

  asram_timing_mon uut (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .bus_addr(bus_addr), .bus_data(bus_data), .host_drv(host_drv),
    .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .bus_mode(bus_mode), .err_flags(err_flags), .err_count(err_count)
  );

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  // hold one bus state for n samples, ending just after a falling edge
  task automatic apply(input logic c, input logic w, input logic o,
                       input logic [18:0] a, input logic [7:0] d,
                       input logic drv, input int n);
    ce_n = c; we_n = w; oe_n = o; bus_addr = a; bus_data = d; host_drv = drv;
    repeat (n) @(negedge clk);
  endtask

  task automatic idle_clear();
    apply(1, 1, 1, AA, DA, 1, 3);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
  endtask

  task automatic expect_err(input string tag, input int flags, input int cnt);
    check({tag, " flags"}, int'(err_flags), flags);
    check({tag, " count"}, int'(err_count), cnt);
  endtask

  task automatic t_reset();
    // R11: reset state, and first address change with ce low is not flagged
    expect_err("R11 reset", 0, 0);
    apply(0, 1, 1, 19'd4, 8'h00, 0, 2);
    expect_err("R11 first change", 0, 0);
  endtask

  task automatic t_modes();
    apply(1, 0, 0, AA, DA, 0, 0); #1 check("R1 standby", int'(bus_mode), 0);
    @(negedge clk);
    apply(0, 1, 0, AA, DA, 0, 0); #1 check("R1 read", int'(bus_mode), 2);
    @(negedge clk);
    apply(0, 1, 1, AA, DA, 0, 0); #1 check("R1 quiet", int'(bus_mode), 3);
    @(negedge clk);
    apply(0, 0, 0, AA, DA, 0, 0); #1 check("R1 write", int'(bus_mode), 1);
    @(negedge clk);
    idle_clear();
  endtask

  task automatic we_write(input int lo_len);
    apply(0, 1, 1, AA, DA, 1, 2);
    apply(0, 0, 1, AA, DA, 1, lo_len);
    apply(0, 1, 1, AA, DA, 1, 2);
    apply(1, 1, 1, AA, DA, 1, 2);
  endtask

  task automatic t_wpulse();
    idle_clear();
    we_write(24);
    expect_err("R2 24 samples", 0, 0);
    we_write(23);
    expect_err("R2 23 samples", 1, 1);
  endtask

  task automatic t_cewin();
    idle_clear();
    apply(0, 0, 1, AA, DA, 1, 32);
    apply(1, 1, 1, AA, DA, 1, 2);
    expect_err("R3 32 samples", 0, 0);
    apply(0, 0, 1, AA, DA, 1, 31);
    apply(1, 1, 1, AA, DA, 1, 2);
    expect_err("R3 31 samples", 2, 1);
  endtask

  task automatic t_setup();
    idle_clear();
    apply(0, 1, 1, AA, DA, 1, 2);
    apply(0, 0, 1, AA, DA, 1, 14);
    apply(0, 0, 1, AA, DB, 1, 16);
    apply(0, 1, 1, AA, DB, 1, 2);
    apply(1, 1, 1, AA, DB, 1, 2);
    expect_err("R4 16 samples", 0, 0);
    apply(0, 1, 1, AA, DB, 1, 2);
    apply(0, 0, 1, AA, DB, 1, 15);
    apply(0, 0, 1, AA, DA, 1, 15);
    apply(0, 1, 1, AA, DA, 1, 2);
    apply(1, 1, 1, AA, DA, 1, 2);
    expect_err("R4 15 samples", 4, 1);
  endtask

  task automatic t_cycle();
    idle_clear();
    apply(1, 1, 1, AB, DA, 1, 2);
    apply(0, 1, 1, AB, DA, 1, 38);
    apply(0, 1, 1, AA, DA, 1, 2);
    apply(1, 1, 1, AA, DA, 1, 2);
    expect_err("R5 40 samples", 0, 0);
    apply(1, 1, 1, AB, DA, 1, 2);
    apply(0, 1, 1, AB, DA, 1, 37);
    apply(0, 1, 1, AA, DA, 1, 2);
    apply(1, 1, 1, AA, DA, 1, 2);
    expect_err("R5 39 samples", 8, 1);
  endtask

  task automatic t_contention();
    idle_clear();
    apply(0, 1, 0, AA, DA, 0, 3);
    apply(0, 0, 0, AA, DA, 0, 12);
    apply(0, 0, 0, AA, DA, 1, 20);
    apply(0, 1, 0, AA, DA, 0, 2);
    apply(1, 1, 1, AA, DA, 0, 2);
    expect_err("R6 drive at 12", 0, 0);
    apply(0, 1, 0, AA, DA, 0, 3);
    apply(0, 0, 0, AA, DA, 0, 5);
    apply(0, 0, 0, AA, DA, 1, 25);
    apply(0, 1, 0, AA, DA, 0, 2);
    apply(1, 1, 1, AA, DA, 0, 2);
    expect_err("R6 drive at 5", 16, 1);
  endtask

  task automatic two_writes(input int gap);
    apply(0, 1, 1, AA, DA, 1, 2);
    apply(0, 0, 1, AA, DA, 1, 30);
    apply(0, 1, 1, AA, DA, 1, gap);
    apply(0, 0, 1, AA, DA, 1, 30);
    apply(0, 1, 1, AA, DA, 1, 2);
    apply(1, 1, 1, AA, DA, 1, 2);
  endtask

  task automatic t_gap();
    idle_clear();
    two_writes(2);
    expect_err("R7 gap 2", 0, 0);
    two_writes(1);
    expect_err("R7 gap 1", 32, 1);
  endtask

  task automatic t_addr_in_write();
    idle_clear();
    apply(1, 1, 1, AA, DA, 1, 2);
    apply(0, 1, 1, AA, DA, 1, 40);
    apply(0, 0, 1, AA, DA, 1, 30);
    apply(0, 0, 1, AB, DA, 1, 30);
    apply(0, 1, 1, AB, DA, 1, 2);
    apply(1, 1, 1, AB, DA, 1, 2);
    expect_err("R8 change in write", 64, 1);
  endtask

  task automatic t_multi();
    idle_clear();
    apply(1, 1, 1, AA, DA, 1, 2);
    apply(0, 1, 1, AA, DA, 1, 2);
    apply(0, 0, 1, AA, DA, 1, 3);
    apply(0, 0, 1, AB, DA, 1, 1);
    expect_err("R9 two rules one edge", 72, 2);
    apply(0, 0, 1, AB, DA, 1, 26);
    apply(0, 1, 1, AB, DA, 1, 2);
    apply(1, 1, 1, AB, DA, 1, 2);
    expect_err("R9 sticky", 72, 2);
  endtask

  task automatic t_clear();
    // state from t_multi still present
    apply(0, 1, 1, AB, DA, 1, 2);
    apply(0, 0, 1, AB, DA, 1, 10);
    clr = 1'b1;
    apply(0, 1, 1, AB, DA, 1, 1);
    clr = 1'b0;
    expect_err("R10 clear with event", 0, 0);
    apply(1, 1, 1, AB, DA, 1, 2);
    expect_err("R10 stays clear", 0, 0);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_modes();
    t_wpulse();
    t_cewin();
    t_setup();
    t_cycle();
    t_contention();
    t_gap();
    t_addr_in_write();
    t_multi();
    t_clear();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule